// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store of a 32-bit core that runs in several processor modes. The instruction stream names sixteen registers, r0 to r15, and the block maps each name onto one slot of a larger physical array. The slot depends on the mode currently in force. Two combinational read ports and one clocked write port serve the datapath. A separate port reads and writes the saved-status word that belongs to the current exception mode.

Registers r0–r7 and r15 have one copy that every mode shares. The fast-interrupt mode has private copies of r8–r12. Each of the five exception modes has its own r13 and r14. User mode and System mode see the same set. A user-bank flag lets privileged code reach the User copies of the banked registers through all three general ports. A read of a slot in the same cycle as a write to that slot returns the new data.

Top module: `bankreg_file`

## Requirements
- R1: After the asynchronous reset, every general register reads zero in every mode, and every saved-status word reads zero.
- R2: r0–r7 and r15 each have a single copy. A value written to one of them in any mode is read back from the next cycle on in every mode.
- R3: The fast-interrupt mode (code 1) has its own r8–r12. All other modes read and write one common copy of r8–r12.
- R4: Each of the modes with codes 1 to 5 has its own r13 and r14. User (code 0) and System (code 7) share one pair.
- R5: When user_bank_i is high, both read ports and the write port use the User copies of r8–r14 regardless of the mode. In User mode the flag changes nothing.
- R6: Each of the modes with codes 1 to 5 owns one saved-status word. That word is read and written through the saved-status port only while that mode is selected.
- R7: In modes 0, 6 and 7 the saved-status port reads zero, and writes made through it change no saved-status word.
- R8: When a read port, or the saved-status port, addresses the slot being written in the same cycle, it returns the write data (write-first).
- R9: The two read ports are independent. Each returns the register named by its own index in the same cycle.
- R10: The mode code is 3 bits: 0 User, 1 fast interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined, 7 System. Code 6 behaves exactly as User.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Current mode code |
| user_bank_i | input | 1 | Route general ports to the User copies |
| rd_a_idx_i | input | 4 | Read port A register index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B register index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General write enable |
| wr_idx_i | input | 4 | General write register index |
| wr_data_i | input | 32 | General write data |
| sr_rd_data_o | output | 32 | Saved-status word of the current mode |
| sr_wr_en_i | input | 1 | Saved-status write enable |
| sr_wr_data_i | input | 32 | Saved-status write data |

## Verification
A wrong bank mapping shows up as a read that returns another mode's value or a stale value. It appears in the first cycle after the write, when the register is read from a mode that should or should not share the slot. A broken bypass shows at once, in the same cycle as the colliding write. A lost isolation of the saved-status words shows on the next read of the saved-status port in the mode that owns the word. Every write in the sequence carries a distinct value, so any aliasing between slots produces a mismatch that the bench can trace to one slot.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int unsigned ARCH_REGS  = 16;
  localparam int unsigned IDX_W      = $clog2(ARCH_REGS);
  localparam int unsigned SHARED_LO  = 8;   // r0..r7 common
  localparam int unsigned FIQ_LO     = 8;   // first fast-bank register
  localparam int unsigned FIQ_CNT    = 5;   // r8..r12
  localparam int unsigned PAIR_LO    = 13;  // r13, r14 banked per mode
  localparam int unsigned PAIR_CNT   = 2;
  localparam int unsigned NUM_BANKS  = 6;   // user + five exception modes
  localparam int unsigned NUM_EXC    = NUM_BANKS - 1;
  localparam int unsigned FIQ_BASE   = SHARED_LO + FIQ_CNT;
  localparam int unsigned PAIR_BASE  = FIQ_BASE + FIQ_CNT;
  localparam int unsigned PC_SLOT    = PAIR_BASE + NUM_BANKS * PAIR_CNT;
  localparam int unsigned PHYS_REGS  = PC_SLOT + 1;
  localparam int unsigned PHYS_W     = $clog2(PHYS_REGS);

  typedef enum logic [2:0] {
    MODE_USR = 3'd0, MODE_FIQ = 3'd1, MODE_IRQ = 3'd2, MODE_SVC = 3'd3,
    MODE_ABT = 3'd4, MODE_UND = 3'd5, MODE_RSV = 3'd6, MODE_SYS = 3'd7
  } mode_e;

  typedef enum logic [2:0] {
    BANK_USR = 3'd0, BANK_FIQ = 3'd1, BANK_IRQ = 3'd2,
    BANK_SVC = 3'd3, BANK_ABT = 3'd4, BANK_UND = 3'd5
  } bank_e;

  function automatic logic is_priv(mode_e m);
    return !(m inside {MODE_USR, MODE_RSV, MODE_SYS});
  endfunction

  function automatic bank_e bank_of(mode_e m, logic user_force);
    bank_e b;
    if (!is_priv(m) || user_force) b = BANK_USR;
    else begin
      unique case (m)
        MODE_FIQ: b = BANK_FIQ;
        MODE_IRQ: b = BANK_IRQ;
        MODE_SVC: b = BANK_SVC;
        MODE_ABT: b = BANK_ABT;
        default:  b = BANK_UND;
      endcase
    end
    return b;
  endfunction
endpackage

// File: rtl/bankreg_map.sv
module bankreg_map
  import bankreg_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  bank_e             bank_i,
  output logic [PHYS_W-1:0] phys_o
);
  always_comb begin
    if (int'(idx_i) < SHARED_LO) begin
      phys_o = PHYS_W'(idx_i);
    end else if (int'(idx_i) < PAIR_LO) begin
      if (bank_i == BANK_FIQ) phys_o = PHYS_W'(FIQ_BASE + int'(idx_i) - FIQ_LO);
      else                    phys_o = PHYS_W'(idx_i);
    end else if (int'(idx_i) < PAIR_LO + PAIR_CNT) begin
      phys_o = PHYS_W'(PAIR_BASE + PAIR_CNT * int'(bank_i) + int'(idx_i) - PAIR_LO);
    end else begin
      phys_o = PHYS_W'(PC_SLOT);
    end
  end
endmodule

// File: rtl/bankreg_gpr.sv
module bankreg_gpr #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 31,
  parameter int unsigned ADDR_W = $clog2(DEPTH),
  parameter int unsigned NRD    = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [NRD-1:0][ADDR_W-1:0] raddr_i,
  output logic [NRD-1:0][DATA_W-1:0] rdata_o
);
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (we_i && int'(waddr_i) < DEPTH) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (we_i && raddr_i[p] == waddr_i)       rdata_o[p] = wdata_i;
      else if (int'(raddr_i[p]) < DEPTH)       rdata_o[p] = mem_q[raddr_i[p]];
      else                                     rdata_o[p] = '0;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(waddr_i) < DEPTH) |=> mem_q[$past(waddr_i)] == $past(wdata_i)); // R2
endmodule

// File: rtl/bankreg_sr.sv
module bankreg_sr
  import bankreg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NUM_EXC-1:0][DATA_W-1:0] sr_q;
  bank_e                          bank;
  logic                           priv;
  logic [$clog2(NUM_EXC)-1:0]     slot;

  assign bank = bank_of(mode_i, 1'b0);
  assign priv = (bank != BANK_USR);
  assign slot = priv ? ($clog2(NUM_EXC))'(int'(bank) - 1) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sr_q <= '0;
    else if (we_i && priv) sr_q[slot] <= wdata_i;
  end

  always_comb begin
    if (!priv)     rdata_o = '0;
    else if (we_i) rdata_o = wdata_i;
    else           rdata_o = sr_q[slot];
  end

  AST_SR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !priv) |=> $stable(sr_q)); // R7
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              user_bank_i,
  input  logic [3:0]        rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] sr_rd_data_o,
  input  logic              sr_wr_en_i,
  input  logic [DATA_W-1:0] sr_wr_data_i
);
  localparam int unsigned NRD = 2;

  mode_e                      mode;
  bank_e                      bank;
  logic [NRD-1:0][IDX_W-1:0]  rd_idx;
  logic [NRD-1:0][PHYS_W-1:0] rd_phys;
  logic [NRD-1:0][DATA_W-1:0] rd_data;
  logic [PHYS_W-1:0]          wr_phys;

  assign mode   = mode_e'(mode_i);
  assign bank   = bank_of(mode, user_bank_i);
  assign rd_idx = {rd_b_idx_i, rd_a_idx_i};

  for (genvar p = 0; p < NRD; p++) begin : g_rmap
    bankreg_map u_map (.idx_i(rd_idx[p]), .bank_i(bank), .phys_o(rd_phys[p]));
  end

  bankreg_map u_wmap (.idx_i(wr_idx_i), .bank_i(bank), .phys_o(wr_phys));

  bankreg_gpr #(.DATA_W(DATA_W), .DEPTH(PHYS_REGS), .ADDR_W(PHYS_W), .NRD(NRD)) u_gpr (
    .clk_i, .rst_ni,
    .we_i(wr_en_i), .waddr_i(wr_phys), .wdata_i(wr_data_i),
    .raddr_i(rd_phys), .rdata_o(rd_data)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  bankreg_sr #(.DATA_W(DATA_W)) u_sr (
    .clk_i, .rst_ni, .mode_i(mode),
    .we_i(sr_wr_en_i), .wdata_i(sr_wr_data_i), .rdata_o(sr_rd_data_o)
  );

  AST_BYPASS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_phys[0] == wr_phys) |-> rd_a_data_o == wr_data_i); // R8
  AST_FIQ_PRIVATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank == BANK_FIQ && rd_a_idx_i inside {[4'd8:4'd12]})
      |-> int'(rd_phys[0]) >= FIQ_BASE && int'(rd_phys[0]) < PAIR_BASE); // R3
  AST_USER_SLOTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (user_bank_i && rd_b_idx_i inside {[4'd8:4'd14]})
      |-> int'(rd_phys[1]) < FIQ_BASE || int'(rd_phys[1]) < PAIR_BASE + PAIR_CNT
          && int'(rd_phys[1]) >= PAIR_BASE); // R5
  AST_SR_UNPRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i inside {3'd0, 3'd6, 3'd7}) |-> sr_rd_data_o == '0); // R7
endmodule

// File: tb/bankreg_file_test.sv
module bankreg_file_test;
  timeunit 1ns; timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode_i = '0;
  logic        user_bank_i = 1'b0;
  logic [3:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, wr_idx_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o, sr_rd_data_o;
  logic        wr_en_i = 1'b0, sr_wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0, sr_wr_data_i = '0;

  always #2.5 clk = ~clk;

  bankreg_file uut (
    .clk_i(clk), .rst_ni, .mode_i, .user_bank_i,
    .rd_a_idx_i, .rd_a_data_o, .rd_b_idx_i, .rd_b_data_o,
    .wr_en_i, .wr_idx_i, .wr_data_i,
    .sr_rd_data_o, .sr_wr_en_i, .sr_wr_data_i
  );

  typedef struct { int req; logic [31:0] ea, eb, es; } item_t;
  item_t q[$];
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  // reference state, organised by requirement
  logic [31:0] sh[16];      // r0..r7, r15
  logic [31:0] hi[2][5];    // r8..r12: 0 common, 1 fast-interrupt
  logic [31:0] pr[6][2];    // r13/r14 per bank
  logic [31:0] sr[6];       // saved status, index = mode code 1..5

  function automatic int bk(int m, bit ub);
    if (ub || m == 0 || m == 6 || m == 7) return 0;
    return m;
  endfunction

  function automatic logic [31:0] mread(int b, int i);
    if (i < 8 || i == 15) return sh[i];
    if (i < 13) return hi[b == 1][i-8];
    return pr[b][i-13];
  endfunction

  function automatic void mwrite(int b, int i, logic [31:0] v);
    if (i < 8 || i == 15) sh[i] = v;
    else if (i < 13) hi[b == 1][i-8] = v;
    else pr[b][i-13] = v;
  endfunction

  task automatic op(int req, int m, bit ub, int ra, int rb, bit we, int wi,
                    logic [31:0] wd, bit swe, logic [31:0] swd);
    int b, sb;
    item_t it;
    @(negedge clk);
    mode_i = 3'(m); user_bank_i = ub; rd_a_idx_i = 4'(ra); rd_b_idx_i = 4'(rb);
    wr_en_i = we; wr_idx_i = 4'(wi); wr_data_i = wd;
    sr_wr_en_i = swe; sr_wr_data_i = swd;
    b  = bk(m, ub);
    sb = (m >= 1 && m <= 5) ? m : 0;
    if (we) mwrite(b, wi, wd);               // write-first: apply before read (R8)
    if (swe && sb != 0) sr[sb] = swd;
    it.req = req; it.ea = mread(b, ra); it.eb = mread(b, rb);
    it.es = (sb != 0) ? sr[sb] : 32'h0;
    q.push_back(it);
  endtask

  task automatic rd(int req, int m, bit ub, int ra, int rb);
    op(req, m, ub, ra, rb, 1'b0, 0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic wr(int req, int m, bit ub, int wi, logic [31:0] wd);
    op(req, m, ub, wi, 0, 1'b1, wi, wd, 1'b0, 32'h0);
  endtask

  task automatic cmp(int req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk); #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        cmp(it.req, "port A", rd_a_data_o, it.ea);
        cmp(it.req, "port B", rd_b_data_o, it.eb);
        cmp(it.req, "saved status", sr_rd_data_o, it.es);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : driver
    foreach (sh[i]) sh[i] = '0;
    foreach (hi[i, j]) hi[i][j] = '0;
    foreach (pr[i, j]) pr[i][j] = '0;
    foreach (sr[i]) sr[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: everything zero after reset
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 8; i++) rd(1, m, 1'b0, i, 15 - i);

    // R2 / R9: shared registers, two independent ports
    for (int i = 0; i < 8; i++) wr(2, i % 6, 1'b0, i, 32'h1000_0000 + i);
    wr(2, 3, 1'b0, 15, 32'h1000_000f);
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 8; i++) rd(9, m, 1'b0, i, 15 - (i % 8));

    // R3: fast-interrupt private r8..r12
    for (int i = 8; i < 13; i++) wr(3, 0, 1'b0, i, 32'h2000_0000 + i);
    for (int i = 8; i < 13; i++) wr(3, 1, 1'b0, i, 32'h3000_0000 + i);
    for (int m = 0; m < 8; m++)
      for (int i = 8; i < 13; i++) rd(3, m, 1'b0, i, 20 - i);
    wr(3, 4, 1'b0, 11, 32'h2100_000b);        // abort shares common copy
    rd(3, 0, 1'b0, 11, 11);
    rd(3, 1, 1'b0, 11, 11);

    // R4: per-mode r13/r14, System shares User
    for (int m = 0; m < 6; m++) begin
      wr(4, m, 1'b0, 13, 32'h4000_0000 + 32'(m * 16));
      wr(4, m, 1'b0, 14, 32'h4100_0000 + 32'(m * 16));
    end
    for (int m = 0; m < 8; m++) rd(4, m, 1'b0, 13, 14);
    wr(4, 7, 1'b0, 14, 32'h4700_0000);
    rd(4, 0, 1'b0, 14, 13);

    // R5: user-bank flag
    wr(5, 1, 1'b1, 9,  32'h5000_0009);
    wr(5, 1, 1'b1, 13, 32'h5000_000d);
    wr(5, 3, 1'b1, 14, 32'h5000_000e);
    rd(5, 0, 1'b0, 9, 13);
    rd(5, 0, 1'b0, 14, 12);
    rd(5, 1, 1'b0, 9, 13);
    rd(5, 1, 1'b1, 9, 13);
    rd(5, 3, 1'b0, 14, 13);
    rd(5, 2, 1'b1, 14, 10);
    wr(5, 0, 1'b1, 13, 32'h5100_000d);
    rd(5, 0, 1'b0, 13, 13);
    rd(5, 7, 1'b1, 13, 14);

    // R6: per-mode saved status
    for (int m = 1; m < 6; m++)
      op(6, m, 1'b0, 0, 1, 1'b0, 0, 32'h0, 1'b1, 32'h6000_0000 + m);
    for (int m = 1; m < 6; m++) rd(6, m, 1'b0, 2, 3);

    // R7 / R10: unprivileged saved-status access
    op(7, 0, 1'b0, 0, 0, 1'b0, 0, 32'h0, 1'b1, 32'hdead_0000);
    op(7, 7, 1'b0, 0, 0, 1'b0, 0, 32'h0, 1'b1, 32'hdead_0007);
    op(10, 6, 1'b0, 13, 9, 1'b0, 0, 32'h0, 1'b1, 32'hdead_0006);
    for (int m = 1; m < 6; m++) rd(7, m, 1'b0, 4, 5);
    rd(10, 6, 1'b0, 14, 12);
    wr(10, 6, 1'b0, 13, 32'ha000_0006);
    rd(10, 0, 1'b0, 13, 14);

    // R8: write-first bypass on both ports and saved status
    op(8, 2, 1'b0, 13, 13, 1'b1, 13, 32'h8000_0002, 1'b0, 32'h0);
    op(8, 1, 1'b0, 10, 3,  1'b1, 10, 32'h8000_000a, 1'b1, 32'h8100_0001);
    op(8, 0, 1'b0, 5, 15,  1'b1, 15, 32'h8000_000f, 1'b0, 32'h0);
    op(8, 4, 1'b1, 14, 12, 1'b1, 14, 32'h8000_000e, 1'b1, 32'h8100_0004);
    rd(8, 2, 1'b0, 13, 14);
    rd(8, 1, 1'b0, 10, 15);
    rd(8, 0, 1'b0, 14, 10);
    rd(8, 4, 1'b0, 14, 13);

    @(negedge clk);
    wr_en_i = 1'b0; sr_wr_en_i = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule